// File: doc/BRIEF.md
# PUSH Immediate Fetcher

This block sits between a byte-wide code memory and a 256-bit operand stack in a bytecode interpreter. When strobed with a program counter, it reads the opcode at that address. If the opcode is one of the push instructions, the block reads the immediate bytes that follow at a rate of one byte per clock. It packs them into a word with the most significant byte first, aligns the result to the low end of the word, and then raises a one-cycle valid pulse. With that pulse it presents the assembled word, the program counter of the next instruction and the static gas cost of the push.

For any other opcode, the block raises a one-cycle not-push pulse the cycle after the strobe and reports the following address as the next program counter. Code addresses at or past the code length read as zero. An opcode fetched past the end is therefore a non-push value, and an immediate that runs past the end is filled with zero bytes.

The code memory is read combinationally. While idle, the block drives the incoming program counter onto the address port. While fetching, it drives its own running address.

Top module: `push_imm_fetch`

## Requirements
- R1: After a synchronous active-low reset, the block holds `busy_o`, `push_valid_o` and `not_push_o` low, and holds `next_pc_o`, `gas_o` and `push_word_o` at zero.
- R2: Opcodes 0x60 to 0x7F are push instructions. Every other opcode, including the boundary values 0x5F and 0x80, gives a single `not_push_o` pulse in the cycle after the accepted start, with `next_pc_o` equal to the start PC plus 1. It gives no `push_valid_o`.
- R3: A push with opcode value `op` carries n = op − 0x5F immediate bytes. `push_valid_o` goes high for exactly one cycle, n+1 cycles after the cycle in which start was accepted, and `busy_o` is low in that cycle.
- R4: The immediate bytes are taken so that the byte at the lowest address is the most significant byte. They occupy the low 8·n bits of `push_word_o`, and all higher bits are zero. PUSH32 (0x7F) fills the whole 256-bit word.
- R5: With the push result, `next_pc_o` equals the start PC plus 1 plus n.
- R6: Any code address at or above `code_len_i` reads as 0x00, both for the opcode and for the immediate bytes.
- R7: `gas_o` is 3 together with `push_valid_o` and 0 together with `not_push_o`.
- R8: A start strobe raised while `busy_o` is high has no effect. The push in progress completes with its own word and next PC, and no extra result appears.
- R9: Immediate bytes are treated only as data. A data byte whose value is a push opcode is packed into the word and is not decoded.
- R10: `code_addr_o` equals `pc_i` while idle. In fetch cycle k (k = 1..n), it equals the start PC plus k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Strobe to decode the instruction at `pc_i` |
| pc_i | input | PC_W | Program counter of the instruction to decode |
| code_len_i | input | PC_W | Number of valid code bytes |
| code_addr_o | output | PC_W | Code memory read address |
| code_byte_i | input | 8 | Code memory read data for `code_addr_o` |
| busy_o | output | 1 | High while immediate bytes are being fetched |
| push_valid_o | output | 1 | One-cycle pulse when a push word is complete |
| not_push_o | output | 1 | One-cycle pulse when the opcode is not a push |
| push_word_o | output | 8·WORD_BYTES | Assembled immediate, qualified by `push_valid_o` |
| next_pc_o | output | PC_W | Program counter after the decoded instruction |
| gas_o | output | GAS_W | Static gas of the decoded instruction |

## Verification
The hardest case to reach from the ports is a start strobe that arrives while a fetch is in progress. The driver can only produce it by raising start during a fetch cycle of a multi-byte push and giving it a different PC at the same time. The scoreboard then expects exactly one result, carrying the original word and next PC. A trailing window after each operation catches any second pulse. Immediates that run past the code length are built by filling the memory above the length with 0xFF. A wrongly fetched byte would therefore show up as nonzero data instead of the required zero.

// File: rtl/pushfetch_pkg.sv
// Package: shared constants and types for the push immediate fetcher.
// Assumes byte-wide code memory and two-state fetch control.
package pushfetch_pkg;

    localparam int BYTE_W      = 8;
    localparam int PUSH_BASE   = 8'h60;

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_FETCH = 1'b1
    } fetch_state_e;

endpackage

// File: rtl/pf_opcode_decode.sv
// Module: pf_opcode_decode
// Classifies an opcode byte as a push and returns its immediate byte count.
// Assumes push opcodes are contiguous from PUSH_BASE, MAX_IMM entries long.
module pf_opcode_decode
    import pushfetch_pkg::*;
#(
    parameter int MAX_IMM = 32,
    parameter int CNT_W   = 6
) (
    input  logic [BYTE_W-1:0] opcode_i,
    output logic              is_push_o,
    output logic [CNT_W-1:0]  imm_cnt_o
);

    logic [BYTE_W-1:0] rel;

    // Offset from the first push opcode, count is offset plus one.
    always_comb begin
        rel       = opcode_i - BYTE_W'(PUSH_BASE);
        is_push_o = (opcode_i >= BYTE_W'(PUSH_BASE)) &&
                    ({1'b0, rel} < (BYTE_W+1)'(MAX_IMM));
        imm_cnt_o = CNT_W'(rel) + CNT_W'(1);
    end

endmodule

// File: rtl/pf_word_shifter.sv
// Module: pf_word_shifter
// Builds the immediate word by shifting each new byte in at the low end.
// Assumes clear and shift are never both asserted in one cycle.
module pf_word_shifter
    import pushfetch_pkg::*;
#(
    parameter int WORD_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [WORD_W-1:0] word_o
);

    // Accumulator: zero at launch, big-endian shift per fetched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
        end else if (clear_i) begin
            word_o <= '0;
        end else if (shift_i) begin
            word_o <= {word_o[WORD_W-BYTE_W-1:0], byte_i};
        end
    end

endmodule

// File: rtl/pf_seq_ctrl.sv
// Module: pf_seq_ctrl
// Sequences one instruction: decodes at the start PC, walks the immediate
// bytes one per clock and registers the result pulses, next PC and gas.
// Assumes the code byte for code_addr_o arrives in the same cycle.
module pf_seq_ctrl
    import pushfetch_pkg::*;
#(
    parameter int PC_W     = 16,
    parameter int CNT_W    = 6,
    parameter int GAS_W    = 8,
    parameter int PUSH_GAS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             is_push_i,
    input  logic [CNT_W-1:0] imm_cnt_i,
    output logic [PC_W-1:0]  code_addr_o,
    output logic             launch_o,
    output logic             shift_o,
    output logic             busy_o,
    output logic             push_valid_o,
    output logic             not_push_o,
    output logic [PC_W-1:0]  next_pc_o,
    output logic [GAS_W-1:0] gas_o
);

    fetch_state_e     state_q;
    logic [PC_W-1:0]  addr_q;
    logic [CNT_W-1:0] remain_q;
    logic             accept;

    // Address mux and control strobes derived from the current state.
    always_comb begin
        busy_o      = (state_q == FS_FETCH);
        code_addr_o = busy_o ? addr_q : pc_i;
        accept      = start_i && !busy_o;
        launch_o    = accept && is_push_i;
        shift_o     = busy_o;
    end

    // State, running address, byte countdown and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= FS_IDLE;
            addr_q       <= '0;
            remain_q     <= '0;
            push_valid_o <= 1'b0;
            not_push_o   <= 1'b0;
            next_pc_o    <= '0;
            gas_o        <= '0;
        end else begin
            push_valid_o <= 1'b0;
            not_push_o   <= 1'b0;
            case (state_q)
                FS_IDLE: begin
                    if (accept) begin
                        if (is_push_i) begin
                            state_q  <= FS_FETCH;
                            addr_q   <= pc_i + PC_W'(1);
                            remain_q <= imm_cnt_i;
                        end else begin
                            not_push_o <= 1'b1;
                            next_pc_o  <= pc_i + PC_W'(1);
                            gas_o      <= '0;
                        end
                    end
                end
                FS_FETCH: begin
                    addr_q   <= addr_q + PC_W'(1);
                    remain_q <= remain_q - CNT_W'(1);
                    if (remain_q == CNT_W'(1)) begin
                        state_q      <= FS_IDLE;
                        push_valid_o <= 1'b1;
                        next_pc_o    <= addr_q + PC_W'(1);
                        gas_o        <= GAS_W'(PUSH_GAS);
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/push_imm_fetch.sv
// Module: push_imm_fetch
// Top: decodes the opcode at a PC and, for push opcodes, assembles the
// following big-endian immediate bytes into a right-aligned word.
// Assumes an asynchronous-read code memory; bytes at or past code_len_i
// read as zero.
module push_imm_fetch
    import pushfetch_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int WORD_BYTES = 32,
    parameter int GAS_W      = 8,
    parameter int PUSH_GAS   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [PC_W-1:0]            pc_i,
    input  logic [PC_W-1:0]            code_len_i,
    output logic [PC_W-1:0]            code_addr_o,
    input  logic [7:0]                 code_byte_i,
    output logic                       busy_o,
    output logic                       push_valid_o,
    output logic                       not_push_o,
    output logic [8*WORD_BYTES-1:0]    push_word_o,
    output logic [PC_W-1:0]            next_pc_o,
    output logic [GAS_W-1:0]           gas_o
);

    localparam int WORD_W = BYTE_W * WORD_BYTES;
    localparam int CNT_W  = $clog2(WORD_BYTES + 1);

    logic [BYTE_W-1:0] code_byte_m;
    logic              is_push;
    logic [CNT_W-1:0]  imm_cnt;
    logic              launch;
    logic              shift;

    // Zero any byte read from beyond the end of the code.
    always_comb begin
        code_byte_m = (code_addr_o < code_len_i) ? code_byte_i : '0;
    end

    pf_opcode_decode #(
        .MAX_IMM (WORD_BYTES),
        .CNT_W   (CNT_W)
    ) u_decode (
        .opcode_i  (code_byte_m),
        .is_push_o (is_push),
        .imm_cnt_o (imm_cnt)
    );

    pf_seq_ctrl #(
        .PC_W     (PC_W),
        .CNT_W    (CNT_W),
        .GAS_W    (GAS_W),
        .PUSH_GAS (PUSH_GAS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pc_i         (pc_i),
        .is_push_i    (is_push),
        .imm_cnt_i    (imm_cnt),
        .code_addr_o  (code_addr_o),
        .launch_o     (launch),
        .shift_o      (shift),
        .busy_o       (busy_o),
        .push_valid_o (push_valid_o),
        .not_push_o   (not_push_o),
        .next_pc_o    (next_pc_o),
        .gas_o        (gas_o)
    );

    pf_word_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (launch),
        .shift_i (shift),
        .byte_i  (code_byte_m),
        .word_o  (push_word_o)
    );

endmodule

// File: rtl/pf_checker.sv
// Module: pf_checker
// Port-level properties of the push immediate fetcher, bound to the top.
// Assumes reset is applied before the first checked cycle.
module pf_checker #(
    parameter int PC_W     = 16,
    parameter int GAS_W    = 8,
    parameter int PUSH_GAS = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [PC_W-1:0]  pc_i,
    input logic [PC_W-1:0]  code_addr_o,
    input logic             busy_o,
    input logic             push_valid_o,
    input logic             not_push_o,
    input logic [PC_W-1:0]  next_pc_o,
    input logic [GAS_W-1:0] gas_o
);

    logic armed;

    // Arms the properties once a reset cycle has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !(push_valid_o && not_push_o)); // R2
    AST_NOTPUSH_PC: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        not_push_o |-> (next_pc_o == $past(pc_i) + PC_W'(1)) && $past(start_i)); // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        push_valid_o |=> !push_valid_o); // R3
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        push_valid_o |-> !busy_o && $past(busy_o)); // R3
    AST_PUSH_GAS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        push_valid_o |-> gas_o == GAS_W'(PUSH_GAS)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (busy_o && $past(busy_o)) |-> code_addr_o == $past(code_addr_o) + PC_W'(1)); // R10

endmodule

bind push_imm_fetch pf_checker #(
    .PC_W     (PC_W),
    .GAS_W    (GAS_W),
    .PUSH_GAS (PUSH_GAS)
) u_pf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .pc_i         (pc_i),
    .code_addr_o  (code_addr_o),
    .busy_o       (busy_o),
    .push_valid_o (push_valid_o),
    .not_push_o   (not_push_o),
    .next_pc_o    (next_pc_o),
    .gas_o        (gas_o)
);

// File: tb/test_push_imm_fetch.sv
// Scoreboard bench: the driver queues expected results computed from the
// code image; a negedge monitor pops and compares each result pulse.
module test_push_imm_fetch;

    localparam int PC_W = 16;
    localparam int GAS_W = 8;

    typedef struct {
        bit           is_push;
        logic [255:0] word;
        logic [15:0]  npc;
        logic [7:0]   gas;
        int           cyc;
        string        tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [15:0]   pc_i = '0;
    logic [15:0]   code_len_i = 16'd64;
    logic [15:0]   code_addr_o;
    logic [7:0]    code_byte_i;
    logic          busy_o, push_valid_o, not_push_o;
    logic [255:0]  push_word_o;
    logic [15:0]   next_pc_o;
    logic [7:0]    gas_o;

    logic [7:0]    mem [0:255];
    exp_t          q[$];
    int            cyc = 0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign code_byte_i = mem[code_addr_o[7:0]];

    push_imm_fetch #(.PC_W(PC_W), .WORD_BYTES(32), .GAS_W(GAS_W), .PUSH_GAS(3)) i_push_imm_fetch (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pc_i(pc_i),
        .code_len_i(code_len_i), .code_addr_o(code_addr_o), .code_byte_i(code_byte_i),
        .busy_o(busy_o), .push_valid_o(push_valid_o), .not_push_o(not_push_o),
        .push_word_o(push_word_o), .next_pc_o(next_pc_o), .gas_o(gas_o)
    );

    function automatic logic [7:0] rd(input int a);
        return (a < int'(code_len_i)) ? mem[a[7:0]] : 8'h00;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: queue the expected result, strobe start, optionally check the
    // fetch addresses and inject a start while busy.
    task automatic issue(input int pc, input string tag, input bit chk_addr, input bit inject);
        exp_t e;
        int   op, n;
        op = rd(pc);
        n  = (op >= 8'h60 && op <= 8'h7F) ? op - 8'h5F : 0;
        e.is_push = (n != 0);
        e.word = '0;
        for (int i = 1; i <= n; i++) e.word = (e.word << 8) | 256'(rd(pc + i));
        e.npc = 16'(pc + 1 + n);
        e.gas = e.is_push ? 8'd3 : 8'd0;
        e.tag = tag;
        @(negedge clk);
        pc_i = 16'(pc);
        start_i = 1'b1;
        e.cyc = cyc + 1 + n;
        q.push_back(e);
        #1;
        if (chk_addr) check(code_addr_o == 16'(pc), "R10", "idle addr", 256'(code_addr_o), 256'(pc));
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start_i = inject && (k == 0);
            if (inject) pc_i = 16'(pc + 3);
            #1;
            if (chk_addr) check(code_addr_o == 16'(pc + 1 + k), "R10", "fetch addr",
                                256'(code_addr_o), 256'(pc + 1 + k));
        end
        @(negedge clk);
        start_i = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare every result pulse against the queue head.
    always @(negedge clk) begin
        if (rst_n && (push_valid_o || not_push_o)) begin
            if (q.size() == 0) begin
                check(1'b0, "R8", "unexpected result", 256'(next_pc_o), 256'(0));
            end else begin
                exp_t e;
                e = q.pop_front();
                check(push_valid_o == e.is_push && not_push_o == !e.is_push, e.tag, "kind",
                      256'(push_valid_o), 256'(e.is_push));
                check(cyc == e.cyc, e.tag, "latency (R3)", 256'(cyc), 256'(e.cyc));
                check(next_pc_o == e.npc, e.tag, "next pc (R5)", 256'(next_pc_o), 256'(e.npc));
                check(gas_o == e.gas, e.tag, "gas (R7)", 256'(gas_o), 256'(e.gas));
                if (e.is_push) check(push_word_o == e.word, e.tag, "word (R4)", push_word_o, e.word);
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        wait (cyc > 100000);
        if (!done) begin
            check(1'b0, "WDOG", "timeout", 256'(cyc), 256'(0));
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        // 0: PUSH1 3, PUSH1 5, ADD, STOP
        mem[0] = 8'h60; mem[1] = 8'h03; mem[2] = 8'h60; mem[3] = 8'h05;
        mem[4] = 8'h01; mem[5] = 8'h00;
        // 6: PUSH32 with a computed pattern
        mem[6] = 8'h7F;
        for (int i = 0; i < 32; i++) mem[7 + i] = 8'(i * 7 + 1);
        // 39: PUSH3 AA BB CC
        mem[39] = 8'h62; mem[40] = 8'hAA; mem[41] = 8'hBB; mem[42] = 8'hCC;
        // 43: PUSH2 with data bytes that look like push opcodes
        mem[43] = 8'h61; mem[44] = 8'h60; mem[45] = 8'h61;
        mem[46] = 8'h5F; mem[47] = 8'h80;
        // 48: PUSH4 used with a start injected while busy
        mem[48] = 8'h63; mem[49] = 8'h11; mem[50] = 8'h22; mem[51] = 8'h33; mem[52] = 8'h44;
        // 60: PUSH6 running past the code length of 64
        mem[60] = 8'h65; mem[61] = 8'hDE; mem[62] = 8'hAD; mem[63] = 8'hBE;
        mem[70] = 8'h60;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !push_valid_o && !not_push_o, "R1", "reset flags",
              256'({busy_o, push_valid_o, not_push_o}), 256'(0));
        check(next_pc_o == 0 && gas_o == 0 && push_word_o == 0, "R1", "reset data",
              push_word_o | 256'(next_pc_o), 256'(0));

        issue(0,  "R4 PUSH1", 1'b1, 1'b0);
        issue(2,  "R5 PUSH1 second", 1'b1, 1'b0);
        issue(4,  "R2 ADD", 1'b1, 1'b0);
        issue(5,  "R2 STOP", 1'b0, 1'b0);
        issue(6,  "R4 PUSH32", 1'b1, 1'b0);
        issue(39, "R5 PUSH3", 1'b1, 1'b0);
        issue(43, "R9 data bytes", 1'b1, 1'b0);
        issue(46, "R2 op 0x5F", 1'b0, 1'b0);
        issue(47, "R2 op 0x80", 1'b0, 1'b0);
        issue(48, "R8 start while busy", 1'b0, 1'b1);
        issue(60, "R6 truncated PUSH6", 1'b1, 1'b0);
        issue(70, "R6 pc past end", 1'b0, 1'b0);
        issue(6,  "R7 PUSH32 again", 1'b0, 1'b0);

        check(q.size() == 0, "R3", "pending results", 256'(q.size()), 256'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule